// File: doc/BRIEF.md
# Multi-Beam Complex Weight-and-Sum Beamformer

The block forms many beams from one time-aligned snapshot of complex channel samples. Every beam holds its own complex weight per channel. It multiplies each channel sample by that weight, sums the products over all channels, then rounds and saturates the sum to a 16-bit complex output sample. All beams work on the same input snapshot at the same time.

Each beam walks the channels one per clock cycle through its own complex multiply-accumulate unit. A snapshot therefore occupies NCH+1 clock cycles. The clock must run at least NCH+1 times faster than the snapshot rate. Weights are written one entry at a time through a simple write port into a staging copy. That copy moves into the working copy only when a new snapshot is accepted. A per-beam enable, sampled at the same moment, decides whether that beam computes and strobes an output for the snapshot.

Top module: `bf_multibeam`

## Requirements
- R1: For each enabled beam b, the output is the rounded, saturated value of the sum over channels c of a[c]·w[b][c]. The real part of each term is aI·wI − aQ·wQ and the imaginary part is aI·wQ + aQ·wI. The sum is accumulated at full width with no wrap. All beams use the same accepted input snapshot.
- R2: Weights are signed 16-bit values with 15 fraction bits. The sum is rounded by adding 2^14 and shifting arithmetically right by 15, so exact halves round toward positive infinity.
- R3: After rounding, results above 32767 are output as 32767, and results below −32768 are output as −32768.
- R4: A snapshot is accepted on a rising edge with `in_valid` high while no snapshot is in progress. `out_valid[b]` goes high NCH+1 edges after the accepting edge and stays high for exactly one cycle. It is low at the edge before.
- R5: While a snapshot is in progress, `in_valid` is ignored. The result equals that of the first snapshot, and no extra output strobe appears afterwards.
- R6: `beam_en` is sampled only at the accepting edge. A beam disabled there gives no `out_valid` strobe for that snapshot, and its `out_i`/`out_q` keep their previous values. Changes to `beam_en` during the computation have no effect.
- R7: A weight write (`cw_we` high, with `cw_beam` and `cw_chan` selecting the entry and `cw_wi`/`cw_wq` giving the value) applies only to snapshots accepted on a later edge. A snapshot already in progress uses the weights it started with.
- R8: After reset, `out_valid` is low, `out_i` and `out_q` are zero, and all weights are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Snapshot present on `in_i`/`in_q` |
| in_i | input | NCH*DW | Real parts, channel c at bits [c*DW +: DW] |
| in_q | input | NCH*DW | Imaginary parts, same layout |
| beam_en | input | NBEAM | Per-beam enable, bit b for beam b |
| cw_we | input | 1 | Weight write strobe |
| cw_beam | input | clog2(NBEAM) | Beam index of the write |
| cw_chan | input | clog2(NCH) | Channel index of the write |
| cw_wi | input | CW | Real part of the weight |
| cw_wq | input | CW | Imaginary part of the weight |
| out_i | output | NBEAM*DW | Beam real outputs, beam b at bits [b*DW +: DW] |
| out_q | output | NBEAM*DW | Beam imaginary outputs, same layout |
| out_valid | output | NBEAM | One-cycle strobe per beam |

## Verification
The bench targets rounding exactly at one half, both signs of full-scale saturation, and the weights being all zero out of reset. A design that truncated instead of rounding would output 0 where 1 is expected. A design that wrapped instead of saturating would flip the sign of full-scale sums. It also writes a weight in the middle of a snapshot. A design without the staging copy would blend old and new weights into one output. Further tests raise `in_valid` and change `beam_en` while a snapshot is busy. A design that re-sampled these would restart, emit a stray strobe, or leak an output from a disabled beam.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int unsigned BF_DW   = 16;
  localparam int unsigned BF_CW   = 16;
  localparam int unsigned BF_FRAC = 15;

  // round half up by frac bits, then clamp to a signed ow-bit range
  function automatic longint bf_round_sat(input longint v, input int unsigned frac,
                                          input int unsigned ow);
    longint r;
    longint hi;
    longint lo;
    r = v;
    if (frac > 0) r = (v + (longint'(1) <<< (frac - 1))) >>> frac;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -(longint'(1) <<< (ow - 1));
    if (r > hi) r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction
endpackage

// File: rtl/bf_seq.sv
module bf_seq #(
  parameter int unsigned NCH  = 32,
  parameter int unsigned DW   = 16,
  localparam int unsigned CNTW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  output logic              start,
  output logic              busy,
  output logic              fin,
  output logic [CNTW-1:0]   idx,
  output logic [DW-1:0]     sel_i,
  output logic [DW-1:0]     sel_q
);
  logic              busy_q, busy_d;
  logic              fin_q, fin_d;
  logic [CNTW-1:0]   cnt_q, cnt_d;
  logic [NCH*DW-1:0] vi_q, vq_q;

  always_comb begin
    start  = in_valid & ~busy_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    fin_d  = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CNTW'(NCH - 1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vi_q <= '0;
      vq_q <= '0;
    end else if (start) begin
      vi_q <= in_i;
      vq_q <= in_q;
    end
  end

  assign busy  = busy_q;
  assign fin   = fin_q;
  assign idx   = cnt_q;
  assign sel_i = vi_q[cnt_q*DW +: DW];
  assign sel_q = vq_q[cnt_q*DW +: DW];

  assert_busy_ignores_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_valid) |=> ($stable(vi_q) && $stable(vq_q)));

  assert_finish_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> fin_q);
endmodule

// File: rtl/bf_coef_bank.sv
module bf_coef_bank #(
  parameter int unsigned NCH  = 32,
  parameter int unsigned CW   = 16,
  localparam int unsigned CNTW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CNTW-1:0] wchan,
  input  logic [CW-1:0]   wi,
  input  logic [CW-1:0]   wq,
  input  logic            load,
  input  logic            busy,
  input  logic [CNTW-1:0] rd_idx,
  output logic [CW-1:0]   wt_i,
  output logic [CW-1:0]   wt_q
);
  logic [NCH-1:0][2*CW-1:0] stage_q, stage_d;
  logic [NCH-1:0][2*CW-1:0] work_q, work_d;

  always_comb begin
    stage_d = stage_q;
    if (we && (int'(wchan) < int'(NCH))) stage_d[wchan] = {wi, wq};
    work_d = load ? stage_q : work_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      work_q  <= '0;
    end else begin
      stage_q <= stage_d;
      work_q  <= work_d;
    end
  end

  assign {wt_i, wt_q} = work_q[rd_idx];

  assert_weights_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> $stable(work_q));
endmodule

// File: rtl/bf_cmac.sv
module bf_cmac #(
  parameter int unsigned NCH  = 32,
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 15,
  localparam int unsigned AW  = DW + CW + 1 + ((NCH > 1) ? $clog2(NCH) : 0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          en_in,
  input  logic          step,
  input  logic          fin,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] a_q,
  input  logic [CW-1:0] w_i,
  input  logic [CW-1:0] w_q,
  output logic [DW-1:0] o_i,
  output logic [DW-1:0] o_q,
  output logic          o_vld
);
  logic                 en_q, en_d;
  logic signed [AW-1:0] acc_i_q, acc_i_d, acc_q_q, acc_q_d;
  logic signed [AW-1:0] ai_x, aq_x, wi_x, wq_x, p_re, p_im;
  logic [DW-1:0]        oi_q, oi_d, oq_q, oq_d;
  logic                 vld_q, vld_d;
  longint               r_i, r_q;

  always_comb begin
    ai_x = {{(AW-DW){a_i[DW-1]}}, a_i};
    aq_x = {{(AW-DW){a_q[DW-1]}}, a_q};
    wi_x = {{(AW-CW){w_i[CW-1]}}, w_i};
    wq_x = {{(AW-CW){w_q[CW-1]}}, w_q};
    p_re = ai_x * wi_x - aq_x * wq_x;
    p_im = ai_x * wq_x + aq_x * wi_x;

    en_d    = start ? en_in : en_q;
    acc_i_d = acc_i_q;
    acc_q_d = acc_q_q;
    if (start && en_in) begin
      acc_i_d = '0;
      acc_q_d = '0;
    end else if (step && en_q) begin
      acc_i_d = acc_i_q + p_re;
      acc_q_d = acc_q_q + p_im;
    end

    r_i   = bf_pkg::bf_round_sat(longint'(acc_i_q), FRAC, DW);
    r_q   = bf_pkg::bf_round_sat(longint'(acc_q_q), FRAC, DW);
    vld_d = fin && en_q;
    oi_d  = oi_q;
    oq_d  = oq_q;
    if (vld_d) begin
      oi_d = r_i[DW-1:0];
      oq_d = r_q[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      acc_i_q <= '0;
      acc_q_q <= '0;
      oi_q    <= '0;
      oq_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      acc_i_q <= acc_i_d;
      acc_q_q <= acc_q_d;
      oi_q    <= oi_d;
      oq_q    <= oq_d;
      vld_q   <= vld_d;
    end
  end

  assign o_i   = oi_q;
  assign o_q   = oq_q;
  assign o_vld = vld_q;

  assert_disabled_beam_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start) |=> ($stable(acc_i_q) && $stable(acc_q_q) && !vld_q));

  assert_single_cycle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  assert_output_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> ($stable(oi_q) && $stable(oq_q)));
endmodule

// File: rtl/bf_multibeam.sv
module bf_multibeam #(
  parameter int unsigned NCH   = 32,
  parameter int unsigned NBEAM = 40,
  parameter int unsigned DW    = bf_pkg::BF_DW,
  parameter int unsigned CW    = bf_pkg::BF_CW,
  parameter int unsigned FRAC  = bf_pkg::BF_FRAC,
  localparam int unsigned CNTW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned BW   = (NBEAM > 1) ? $clog2(NBEAM) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [NCH*DW-1:0]   in_i,
  input  logic [NCH*DW-1:0]   in_q,
  input  logic [NBEAM-1:0]    beam_en,
  input  logic                cw_we,
  input  logic [BW-1:0]       cw_beam,
  input  logic [CNTW-1:0]     cw_chan,
  input  logic [CW-1:0]       cw_wi,
  input  logic [CW-1:0]       cw_wq,
  output logic [NBEAM*DW-1:0] out_i,
  output logic [NBEAM*DW-1:0] out_q,
  output logic [NBEAM-1:0]    out_valid
);
  logic            start, busy, fin;
  logic [CNTW-1:0] idx;
  logic [DW-1:0]   sel_i, sel_q;

  bf_seq #(.NCH(NCH), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .start(start), .busy(busy), .fin(fin), .idx(idx), .sel_i(sel_i), .sel_q(sel_q)
  );

  for (genvar b = 0; b < NBEAM; b++) begin : g_beam
    logic          we_b;
    logic [CW-1:0] wt_i, wt_q;

    assign we_b = cw_we && (cw_beam == BW'(b));

    bf_coef_bank #(.NCH(NCH), .CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we_b), .wchan(cw_chan), .wi(cw_wi), .wq(cw_wq),
      .load(start), .busy(busy), .rd_idx(idx), .wt_i(wt_i), .wt_q(wt_q)
    );

    bf_cmac #(.NCH(NCH), .DW(DW), .CW(CW), .FRAC(FRAC)) u_mac (
      .clk(clk), .rst_n(rst_n), .start(start), .en_in(beam_en[b]), .step(busy),
      .fin(fin), .a_i(sel_i), .a_q(sel_q), .w_i(wt_i), .w_q(wt_q),
      .o_i(out_i[b*DW +: DW]), .o_q(out_q[b*DW +: DW]), .o_vld(out_valid[b])
    );
  end
endmodule

// File: tb/test_bf_multibeam.sv
module test_bf_multibeam;
  localparam int NCH = 4;
  localparam int NB  = 3;
  localparam int NV  = 6;

  // stimulus table: per vector, I and Q of channels 0..3
  localparam int TV_I [NV][NCH] = '{
    '{1, 0, 0, 0},
    '{100, 300, -500, 700},
    '{32767, 32767, 32767, 32767},
    '{-32768, -32768, -32768, -32768},
    '{-1, 1, 2, -3},
    '{12345, -7777, 32000, 5}
  };
  localparam int TV_Q [NV][NCH] = '{
    '{0, 0, 0, 0},
    '{-200, 400, 600, -800},
    '{32767, 32767, 32767, 32767},
    '{-32768, -32768, -32768, -32768},
    '{1, -1, 3, -2},
    '{-23456, 8888, -32000, 5}
  };

  logic              clk, rst_n, in_valid, cw_we;
  logic [NCH*16-1:0] in_i, in_q;
  logic [NB-1:0]     beam_en;
  logic [1:0]        cw_beam, cw_chan;
  logic [15:0]       cw_wi, cw_wq;
  logic [NB*16-1:0]  out_i, out_q;
  logic [NB-1:0]     out_valid;

  int n_chk, n_bad;
  int cur_i [NCH];
  int cur_q [NCH];
  int wm_i [NB][NCH];
  int wm_q [NB][NCH];
  int last_i [NB];
  int last_q [NB];

  bf_multibeam #(.NCH(NCH), .NBEAM(NB)) i_bf_multibeam (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .beam_en(beam_en), .cw_we(cw_we), .cw_beam(cw_beam), .cw_chan(cw_chan),
    .cw_wi(cw_wi), .cw_wq(cw_wq), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rsat(input longint v);
    longint r;
    r = (v + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic void model(input int b, output int ei, output int eq);
    longint si, sq;
    si = 0;
    sq = 0;
    for (int c = 0; c < NCH; c++) begin
      si += longint'(cur_i[c]) * wm_i[b][c] - longint'(cur_q[c]) * wm_q[b][c];
      sq += longint'(cur_i[c]) * wm_q[b][c] + longint'(cur_q[c]) * wm_i[b][c];
    end
    ei = rsat(si);
    eq = rsat(sq);
  endfunction

  function automatic int oi(input int b);
    return int'($signed(out_i[b*16 +: 16]));
  endfunction
  function automatic int oq(input int b);
    return int'($signed(out_q[b*16 +: 16]));
  endfunction

  task automatic put_vec();
    for (int c = 0; c < NCH; c++) begin
      in_i[c*16 +: 16] = 16'(cur_i[c]);
      in_q[c*16 +: 16] = 16'(cur_q[c]);
    end
  endtask

  task automatic wr_w(input int b, input int c, input int wi, input int wq);
    @(negedge clk);
    cw_we = 1'b1; cw_beam = 2'(b); cw_chan = 2'(c); cw_wi = 16'(wi); cw_wq = 16'(wq);
    @(negedge clk);
    cw_we = 1'b0;
    wm_i[b][c] = wi;
    wm_q[b][c] = wq;
  endtask

  function automatic void set_cur(input int v);
    for (int c = 0; c < NCH; c++) begin
      cur_i[c] = TV_I[v][c];
      cur_q[c] = TV_Q[v][c];
    end
  endfunction

  // action: 0 none, 1 enable all beams mid-run, 2 weight write mid-run, 3 in_valid mid-run
  task automatic run_vec(input string tag, input int action);
    bit en_s [NB];
    int ei, eq;
    int ki [NCH];
    int kq [NCH];
    for (int b = 0; b < NB; b++) en_s[b] = beam_en[b];
    @(negedge clk);
    put_vec();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      @(negedge clk);
      if (k == 1 && action == 1) beam_en = '1;
      if (k == 1 && action == 2) begin
        cw_we = 1'b1; cw_beam = 2'd0; cw_chan = 2'd0; cw_wi = 16'hC000; cw_wq = 16'h2000;
      end
      if (k == 2 && action == 2) cw_we = 1'b0;
      if (k == 1 && action == 3) begin
        for (int c = 0; c < NCH; c++) begin
          ki[c] = cur_i[c];
          kq[c] = cur_q[c];
          cur_i[c] = TV_I[3][c];
          cur_q[c] = TV_Q[3][c];
        end
        put_vec();
        in_valid = 1'b1;
      end
      if (k == 3 && action == 3) begin
        in_valid = 1'b0;
        for (int c = 0; c < NCH; c++) begin
          cur_i[c] = ki[c];
          cur_q[c] = kq[c];
        end
      end
    end
    chk(out_valid == '0, "R4 early strobe", int'(out_valid), 0);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      if (en_s[b]) begin
        model(b, ei, eq);
        chk(out_valid[b] == 1'b1, {tag, " valid"}, int'(out_valid[b]), 1);
        chk(oi(b) == ei, {tag, " I"}, oi(b), ei);
        chk(oq(b) == eq, {tag, " Q"}, oq(b), eq);
        last_i[b] = ei;
        last_q[b] = eq;
      end else begin
        chk(out_valid[b] == 1'b0, "R6 disabled strobe", int'(out_valid[b]), 0);
        chk(oi(b) == last_i[b], "R6 held I", oi(b), last_i[b]);
        chk(oq(b) == last_q[b], "R6 held Q", oq(b), last_q[b]);
      end
    end
    @(negedge clk);
    chk(out_valid == '0, "R4 strobe width", int'(out_valid), 0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0; beam_en = '1;
    cw_we = 1'b0; cw_beam = '0; cw_chan = '0; cw_wi = '0; cw_wq = '0;
    for (int b = 0; b < NB; b++) begin
      last_i[b] = 0;
      last_q[b] = 0;
      for (int c = 0; c < NCH; c++) begin
        wm_i[b][c] = 0;
        wm_q[b][c] = 0;
      end
    end
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R8 reset valid", int'(out_valid), 0);
    chk(out_i == '0 && out_q == '0, "R8 reset data", int'(out_i[15:0]), 0);
    rst_n = 1'b1;

    // weights are zero out of reset
    set_cur(1);
    run_vec("R8 zero weights", 0);

    for (int c = 0; c < NCH; c++) begin
      wr_w(0, c, 16384, 0);
      wr_w(1, c, 0, 16384);
    end
    wr_w(2, 0, -32768, 0);
    wr_w(2, 1, 32767, -32768);
    wr_w(2, 2, 1000, -2000);
    wr_w(2, 3, -5, 7);

    // table walk
    for (int v = 0; v < NV; v++) begin
      set_cur(v);
      if (v == 0) run_vec("R2 rounding", 0);
      else if (v == 2 || v == 3) run_vec("R3 saturation", 0);
      else run_vec("R1 weighted sum", 0);
    end

    // beam 1 disabled at acceptance, enabled mid-run: must stay disabled
    beam_en = 3'b101;
    set_cur(4);
    run_vec("R6 enabled beams", 1);
    beam_en = '1;

    // weight write mid-run uses old weights, next snapshot uses new ones
    set_cur(5);
    run_vec("R7 old weights", 2);
    wm_i[0][0] = -16384;
    wm_q[0][0] = 8192;
    run_vec("R7 new weights", 0);

    // in_valid while busy is ignored
    set_cur(1);
    run_vec("R5 first snapshot kept", 3);
    for (int k = 0; k < NCH + 3; k++) begin
      @(negedge clk);
      chk(out_valid == '0, "R5 stray strobe", int'(out_valid), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule